// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with a byte-wide register interface. It has two addresses: a control and status register and a data buffer. A write to the data buffer loads the transmit shifter and starts a frame. A read of the data buffer returns the last accepted received byte. Every bit period is timed by an oversampling enable, `os_tick`, which the baud generator outside the block supplies at sixteen times the bit rate.

Two field bits in the control register select the frame format. There is one format that carries eight data bits and two formats that carry nine. In the nine-bit formats the extra transmitted bit comes from a control field, and the extra received bit is kept in another. An address-filter option lets a receiver drop frames whose ninth bit is clear, which is the usual way to address one station among several on a shared line. Hardware sets the completion flags for transmit and receive and a framing-error flag. Only software writes clear them. The top bit of the control register is shared: an external select chooses whether it is the framing-error flag or the high mode bit.

Top module: `ser9_port`

## Requirements
- R1: After reset the control register reads 0x00 under either setting of `fe_sel`, and `txd` is high.
- R2: Control bit 7 reads and writes the framing-error flag while `fe_sel` is 1, and the high mode bit while `fe_sel` is 0. Each of the two holds its value while the other is selected.
- R3: In mode {bit7,bit6}=01, a data write sends one low start bit, then the 8 data bits LSB first, then one high stop bit. Each bit lasts 16 `os_tick` pulses. Control bit 3 has no effect on this frame.
- R4: In modes 10 and 11, control bit 3 is sent as a ninth bit between the eighth data bit and the stop bit.
- R5: Control bit 1 (transmit done) becomes 1 when the last data bit (the eighth or the ninth) ends. It stays 1 until software writes it to 0.
- R6: While control bit 4 is 1, a received frame sets control bit 0 (receive done) after the stop bit is sampled, and its byte becomes readable at the data address. While bit 4 is 0, frames leave both unchanged.
- R7: Control bit 2 receives the sampled stop bit in mode 01 and the received ninth bit in modes 10 and 11.
- R8: A stop bit sampled low sets the framing-error flag. The flag stays set through later good frames until software writes bit 7 to 0 with `fe_sel` high.
- R9: With control bit 5 set in a nine-bit mode, a frame whose ninth bit is 0 leaves bit 0, bit 2 and the data buffer unchanged. A frame whose ninth bit is 1 is accepted.
- R10: In mode 00 a data write sends nothing and does not set bit 1, and received frames are ignored.
- R11: A data write that arrives while a frame is being sent is ignored. The current frame completes unchanged and no second frame follows.
- R12: The receiver samples the line 8 ticks after it sees it low. If the line is high again by then, the start is rejected and no frame is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| fe_sel | input | 1 | 1: control bit 7 is the framing-error flag; 0: it is the high mode bit |
| bus_sel | input | 1 | Register select: 0 control, 1 data buffer |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
The in-line assertions check, on every cycle, the rules that only concern where a flag may come from. Transmit and receive done can rise only on a frame event or a register write. The framing-error flag can fall only through a write while it is selected. A filtered frame never touches the receive state. The transmitter ignores loads while busy, keeps the line high while idle, and stays idle in mode 00. Frame content cannot be shown this way: bit order, the placement of the ninth bit, the stop value captured into bit 2, flag timing relative to the last data bit, and rejection of a short start pulse. The bench shows these by decoding the line and by loopback sweeps in every frame mode.

// File: rtl/ser9_pkg.sv
package ser9_pkg;

   localparam int BUS_W = 8;

   // control register field positions (software decodes these)
   localparam int F_RXDONE = 0;
   localparam int F_TXDONE = 1;
   localparam int F_RXNINE = 2;
   localparam int F_TXNINE = 3;
   localparam int F_RXEN   = 4;
   localparam int F_FILT   = 5;
   localparam int F_MLO    = 6;
   localparam int F_MHI    = 7;

   typedef enum logic [1:0] {
      FMT_OFF   = 2'b00,
      FMT_8     = 2'b01,
      FMT_9A    = 2'b10,
      FMT_9B    = 2'b11
   } ser_fmt_e;

   function automatic logic fmt_has_nine(input ser_fmt_e f);
      return f[1];
   endfunction

endpackage

// File: rtl/ser9_tx.sv
module ser9_tx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              nine,
   input  logic              bit9,
   output logic              txd,
   output logic              busy,
   output logic              fin
);

   localparam int FW = DATA_W + 3;
   localparam int CW = $clog2(OVS);
   localparam int BW = $clog2(FW);

   logic [FW-1:0] frame;
   logic [BW-1:0] bits_left;
   logic [CW-1:0] tcnt;
   logic          busy_q;
   logic          txd_q;
   logic          fin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame     <= '0;
         bits_left <= '0;
         tcnt      <= '0;
         busy_q    <= 1'b0;
         txd_q     <= 1'b1;
         fin_q     <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (!busy_q) begin
            if (load) begin
               frame     <= {1'b1, (nine ? bit9 : 1'b1), load_data, 1'b0};
               bits_left <= nine ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
               tcnt      <= '0;
               busy_q    <= 1'b1;
               txd_q     <= 1'b0;
            end
         end else if (tick) begin
            if (tcnt == CW'(OVS - 1)) begin
               tcnt <= '0;
               if (bits_left == '0) begin
                  busy_q <= 1'b0;
                  txd_q  <= 1'b1;
               end else begin
                  frame     <= frame >> 1;
                  txd_q     <= frame[1];
                  bits_left <= bits_left - 1'b1;
                  if (bits_left == BW'(1))
                     fin_q <= 1'b1;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end

   assign txd  = txd_q;
   assign busy = busy_q;
   assign fin  = fin_q;

   // R11
   tx_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && load && !tick) |=> $stable(frame));

   // R3
   tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> txd_q);

endmodule

// File: rtl/ser9_rx.sv
module ser9_rx #(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              nine_in,
   input  logic              rxd,
   output logic              vld,
   output logic [DATA_W-1:0] data,
   output logic              b9,
   output logic              stop,
   output logic              nine
);

   localparam int SW = DATA_W + 2;
   localparam int CW = $clog2(OVS);
   localparam int NW = $clog2(SW + 1);

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rx_st_e;

   logic [SYNC_N-1:0] sync;
   logic              rxs;

   always_ff @(posedge clk) begin
      if (!rst_n) sync[0] <= 1'b1;
      else        sync[0] <= rxd;
   end

   for (genvar g = 1; g < SYNC_N; g++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) sync[g] <= 1'b1;
         else        sync[g] <= sync[g-1];
      end
   end

   assign rxs = sync[SYNC_N-1];

   rx_st_e        st;
   logic [CW-1:0] cnt;
   logic [NW-1:0] n;
   logic [SW-1:0] sh;
   logic [SW-1:0] nxt;
   logic          last;
   logic          vld_q;
   logic [DATA_W-1:0] data_q;
   logic          b9_q;
   logic          stop_q;
   logic          nine_q;

   always_comb begin
      nxt  = {rxs, sh[SW-1:1]};
      last = (n == (nine_q ? NW'(SW - 1) : NW'(SW - 2)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         n      <= '0;
         sh     <= '0;
         vld_q  <= 1'b0;
         data_q <= '0;
         b9_q   <= 1'b0;
         stop_q <= 1'b1;
         nine_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (st)
            RX_IDLE: begin
               if (tick && en && !rxs) begin
                  st     <= RX_START;
                  cnt    <= '0;
                  nine_q <= nine_in;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt == CW'(OVS / 2 - 1)) begin
                     cnt <= '0;
                     n   <= '0;
                     st  <= rxs ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            RX_BITS: begin
               if (tick) begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     sh  <= nxt;
                     n   <= n + 1'b1;
                     if (last) begin
                        vld_q  <= 1'b1;
                        stop_q <= nxt[SW-1];
                        if (nine_q) begin
                           data_q <= nxt[DATA_W-1:0];
                           b9_q   <= nxt[DATA_W];
                        end else begin
                           data_q <= nxt[DATA_W:1];
                           b9_q   <= nxt[SW-1];
                        end
                        st <= RX_HOLD;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: begin
               if (rxs) st <= RX_IDLE;
            end
         endcase
      end
   end

   assign vld  = vld_q;
   assign data = data_q;
   assign b9   = b9_q;
   assign stop = stop_q;
   assign nine = nine_q;

   // R6
   rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_BITS) |-> (n <= NW'(SW - 1)));

   // R12
   rx_vld_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(st == RX_BITS));

endmodule

// File: rtl/ser9_regs.sv
module ser9_regs
   import ser9_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fe_sel,
   input  logic              wr_ctl,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              rx_vld,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_b9,
   input  logic              rx_stop,
   input  logic              rx_nine,
   input  logic              tx_fin,
   output logic [BUS_W-1:0]  ctl_rd,
   output logic [DATA_W-1:0] rbuf,
   output ser_fmt_e          fmt,
   output logic              rx_on,
   output logic              tx_nine_bit
);

   logic fe, mhi, mlo, filt, rxen, txn, rxn, txdone, rxdone;
   logic accept;
   logic [DATA_W-1:0] rbuf_q;

   assign accept = rx_vld && !(filt && rx_nine && !rx_b9);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fe <= 1'b0; mhi <= 1'b0; mlo <= 1'b0; filt <= 1'b0;
         rxen <= 1'b0; txn <= 1'b0; rxn <= 1'b0;
         txdone <= 1'b0; rxdone <= 1'b0;
      end else begin
         if (wr_ctl) begin
            if (fe_sel) fe  <= wdata[F_MHI];
            else        mhi <= wdata[F_MHI];
            mlo    <= wdata[F_MLO];
            filt   <= wdata[F_FILT];
            rxen   <= wdata[F_RXEN];
            txn    <= wdata[F_TXNINE];
            rxn    <= wdata[F_RXNINE];
            txdone <= wdata[F_TXDONE];
            rxdone <= wdata[F_RXDONE];
         end
         if (tx_fin) txdone <= 1'b1;
         if (accept) begin
            rxdone <= 1'b1;
            rxn    <= rx_nine ? rx_b9 : rx_stop;
         end
         if (rx_vld && !rx_stop) fe <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) rbuf_q <= rx_data;
   end

   always_comb begin
      ctl_rd           = '0;
      ctl_rd[F_MHI]    = fe_sel ? fe : mhi;
      ctl_rd[F_MLO]    = mlo;
      ctl_rd[F_FILT]   = filt;
      ctl_rd[F_RXEN]   = rxen;
      ctl_rd[F_TXNINE] = txn;
      ctl_rd[F_RXNINE] = rxn;
      ctl_rd[F_TXDONE] = txdone;
      ctl_rd[F_RXDONE] = rxdone;
   end

   assign fmt         = ser_fmt_e'({mhi, mlo});
   assign rx_on       = rxen;
   assign tx_nine_bit = txn;
   assign rbuf        = rbuf_q;

   // R5
   txdone_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txdone) |-> $past(tx_fin || wr_ctl));

   // R6
   rxdone_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rxdone) |-> $past(rx_vld || wr_ctl));

   // R8
   fe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe) |-> $past(wr_ctl && fe_sel));

   // R9
   filt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld && filt && rx_nine && !rx_b9 && !wr_ctl) |=> ($stable(rxdone) && $stable(rxn) && $stable(rbuf_q)));

endmodule

// File: rtl/ser9_port.sv
module ser9_port
   import ser9_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             os_tick,
   input  logic             fe_sel,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             rxd,
   output logic             txd
);

   if (DATA_W < 5 || DATA_W > BUS_W) begin : g_bad_width
      $error("ser9_port: DATA_W must lie between 5 and the bus width");
   end
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("ser9_port: OVS must be even and at least 4");
   end
   if (SYNC_N < 1) begin : g_bad_sync
      $error("ser9_port: SYNC_N must be at least 1");
   end

   logic              wr_ctl, wr_dat;
   ser_fmt_e          fmt;
   logic              rx_on, tx_nine_bit;
   logic [BUS_W-1:0]  ctl_rd;
   logic [DATA_W-1:0] rbuf;
   logic [BUS_W-1:0]  rbuf_ext;
   logic              tx_busy, tx_fin, tx_load;
   logic              rx_vld, rx_b9, rx_stop, rx_nine;
   logic [DATA_W-1:0] rx_data;

   assign wr_ctl  = bus_wr && !bus_sel;
   assign wr_dat  = bus_wr && bus_sel;
   assign tx_load = wr_dat && (fmt != FMT_OFF);

   ser9_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .fe_sel     (fe_sel),
      .wr_ctl     (wr_ctl),
      .wdata      (bus_wdata),
      .rx_vld     (rx_vld),
      .rx_data    (rx_data),
      .rx_b9      (rx_b9),
      .rx_stop    (rx_stop),
      .rx_nine    (rx_nine),
      .tx_fin     (tx_fin),
      .ctl_rd     (ctl_rd),
      .rbuf       (rbuf),
      .fmt        (fmt),
      .rx_on      (rx_on),
      .tx_nine_bit(tx_nine_bit)
   );

   ser9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (os_tick),
      .load     (tx_load),
      .load_data(bus_wdata[DATA_W-1:0]),
      .nine     (fmt_has_nine(fmt)),
      .bit9     (tx_nine_bit),
      .txd      (txd),
      .busy     (tx_busy),
      .fin      (tx_fin)
   );

   ser9_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_N(SYNC_N)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (os_tick),
      .en     (rx_on && (fmt != FMT_OFF)),
      .nine_in(fmt_has_nine(fmt)),
      .rxd    (rxd),
      .vld    (rx_vld),
      .data   (rx_data),
      .b9     (rx_b9),
      .stop   (rx_stop),
      .nine   (rx_nine)
   );

   if (DATA_W == BUS_W) begin : g_full
      assign rbuf_ext = rbuf;
   end else begin : g_pad
      assign rbuf_ext = {{(BUS_W - DATA_W){1'b0}}, rbuf};
   end

   assign bus_rdata = bus_sel ? rbuf_ext : ctl_rd;

   // R10
   off_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_OFF && !tx_busy) |=> !tx_busy);

endmodule

// File: tb/ser9_port_test.sv
module ser9_port_test;

   localparam int BITC = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] div = 2'd0;
   logic       fe_sel = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       txd;
   logic       loop = 1'b0;
   logic       drv = 1'b1;
   logic       rxd;
   logic       done = 1'b0;
   int         nchk = 0;
   int         nfail = 0;

   assign rxd = loop ? txd : drv;

   always #5 clk = ~clk;

   always @(negedge clk) begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
   end

   ser9_port uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (tick),
      .fe_sel   (fe_sel),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .rxd      (rxd),
      .txd      (txd)
   );

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      @(negedge clk);
      bus_sel = sel;
      #1 v = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic send(input logic [7:0] d, input logic nine, input logic b9, input logic stopv);
      @(negedge clk);
      drv = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         drv = d[i];
         repeat (BITC) @(negedge clk);
      end
      if (nine) begin
         drv = b9;
         repeat (BITC) @(negedge clk);
      end
      drv = stopv;
      repeat (BITC) @(negedge clk);
      drv = 1'b1;
      repeat (BITC) @(negedge clk);
   endtask

   task automatic capture(input logic nine, output logic [7:0] d, output logic b9,
                          output logic stp, output logic st_ok,
                          output logic ti_last, output logic ti_stop);
      while (txd !== 1'b0) @(negedge clk);
      repeat (BITC / 2) @(negedge clk);
      st_ok = (txd == 1'b0);
      b9 = 1'b1;
      ti_last = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (BITC) @(negedge clk);
         d[i] = txd;
         if (i == 7) ti_last = bus_rdata[1];
      end
      if (nine) begin
         repeat (BITC) @(negedge clk);
         b9 = txd;
         ti_last = bus_rdata[1];
      end
      repeat (BITC) @(negedge clk);
      stp = txd;
      ti_stop = bus_rdata[1];
      repeat (BITC) @(negedge clk);
   endtask

   task automatic watch_idle(input int clocks, output int lows);
      lows = 0;
      for (int i = 0; i < clocks; i++) begin
         @(negedge clk);
         if (txd == 1'b0) lows++;
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v, d;
      logic b9, stp, st_ok, ti_last, ti_stop;
      logic [7:0] last_v;
      int lows;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(1'b0, v); check("R1 ctrl", v, 8'h00);
      fe_sel = 1'b1;
      rd(1'b0, v); check("R1 ctrl fe view", v, 8'h00);
      fe_sel = 1'b0;
      check("R1 txd idle", txd, 1);

      // R2 shared top bit
      wr(1'b0, 8'h00);
      fe_sel = 1'b1;
      wr(1'b0, 8'h80);
      rd(1'b0, v); check("R2 flag view", v, 8'h80);
      fe_sel = 1'b0;
      rd(1'b0, v); check("R2 mode view", v, 8'h00);
      wr(1'b0, 8'h80);
      fe_sel = 1'b1;
      wr(1'b0, 8'h00);
      rd(1'b0, v); check("R2 flag cleared", v, 8'h00);
      fe_sel = 1'b0;
      rd(1'b0, v); check("R2 mode kept", v, 8'h80);

      // R10 mode 00 idle
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h55);
      watch_idle(2 * BITC, lows);
      check("R10 no tx", lows, 0);
      rd(1'b0, v); check("R10 no txdone", v, 8'h10);
      send(8'h5A, 1'b0, 1'b0, 1'b1);
      rd(1'b0, v); check("R10 no rx", v, 8'h10);

      // R3 8-bit frame with bit3 clear
      wr(1'b0, 8'h50);
      wr(1'b1, 8'hA5);
      capture(1'b0, d, b9, stp, st_ok, ti_last, ti_stop);
      check("R3 start", st_ok, 1);
      check("R3 data", d, 8'hA5);
      check("R3 stop", stp, 1);
      check("R5 not before last bit", ti_last, 0);
      check("R5 set at stop", ti_stop, 1);
      repeat (BITC) @(negedge clk);
      rd(1'b0, v); check("R5 persists", v, 8'h52);
      wr(1'b0, 8'h50);
      rd(1'b0, v); check("R5 cleared", v, 8'h50);

      // R4 nine-bit frames
      wr(1'b0, 8'h98);
      wr(1'b1, 8'h3C);
      capture(1'b1, d, b9, stp, st_ok, ti_last, ti_stop);
      check("R4 data 10", d, 8'h3C);
      check("R4 ninth 1", b9, 1);
      check("R4 stop", stp, 1);
      check("R5 after ninth", {ti_last, ti_stop}, 2'b01);
      wr(1'b0, 8'hD0);
      wr(1'b1, 8'hC3);
      capture(1'b1, d, b9, stp, st_ok, ti_last, ti_stop);
      check("R4 data 11", d, 8'hC3);
      check("R4 ninth 0", b9, 0);
      check("R4 stop 11", stp, 1);

      // R11 write during busy
      wr(1'b0, 8'h50);
      wr(1'b1, 8'h6E);
      repeat (10) @(negedge clk);
      wr(1'b1, 8'h99);
      capture(1'b0, d, b9, stp, st_ok, ti_last, ti_stop);
      check("R11 first frame kept", d, 8'h6E);
      watch_idle(2 * BITC, lows);
      check("R11 no second frame", lows, 0);

      // R6 R7 loopback sweep over all frame modes
      loop = 1'b1;
      last_v = 8'h00;
      for (int m = 0; m < 3; m++) begin
         logic [7:0] base;
         logic       nine;
         base = (m == 0) ? 8'h50 : ((m == 1) ? 8'h90 : 8'hD0);
         nine = (m != 0);
         for (int i = 0; i < 16; i++) begin
            logic [7:0] tv;
            logic       tb;
            tv = 8'((i * 37 + 5 + m * 11) & 255);
            tb = i[0];
            wr(1'b0, base | (tb ? 8'h08 : 8'h00));
            wr(1'b1, tv);
            repeat (12 * BITC) @(negedge clk);
            rd(1'b1, v); check("R6 loop data", v, tv);
            rd(1'b0, v);
            check("R6 rx done", v[0], 1);
            check("R5 tx done", v[1], 1);
            check("R7 rx ninth", v[2], nine ? tb : 1'b1);
            last_v = tv;
         end
      end
      loop = 1'b0;
      repeat (BITC) @(negedge clk);

      // R6 receiver disabled
      wr(1'b0, 8'h40);
      send(8'h42, 1'b0, 1'b0, 1'b1);
      rd(1'b0, v); check("R6 disabled flag", v, 8'h40);
      rd(1'b1, v); check("R6 disabled buffer", v, last_v);

      // R8 framing error
      wr(1'b0, 8'h50);
      fe_sel = 1'b1;
      send(8'h81, 1'b0, 1'b0, 1'b0);
      rd(1'b0, v);
      check("R8 flag set", v[7], 1);
      check("R7 stop low kept", v[2], 0);
      rd(1'b1, v); check("R8 data", v, 8'h81);
      send(8'h18, 1'b0, 1'b0, 1'b1);
      rd(1'b0, v); check("R8 flag persists", v[7], 1);
      wr(1'b0, 8'h50);
      rd(1'b0, v); check("R8 flag cleared", v, 8'h50);
      fe_sel = 1'b0;

      // R9 address filter
      wr(1'b0, 8'hF0);
      send(8'h33, 1'b1, 1'b0, 1'b1);
      rd(1'b0, v); check("R9 dropped flags", v, 8'hF0);
      rd(1'b1, v); check("R9 dropped buffer", v, 8'h18);
      send(8'h77, 1'b1, 1'b1, 1'b1);
      rd(1'b0, v); check("R9 accepted flags", v, 8'hF5);
      rd(1'b1, v); check("R9 accepted buffer", v, 8'h77);

      // R12 short start pulse
      wr(1'b0, 8'h50);
      @(negedge clk);
      drv = 1'b0;
      repeat (16) @(negedge clk);
      drv = 1'b1;
      repeat (2 * BITC) @(negedge clk);
      rd(1'b0, v); check("R12 glitch rejected", v, 8'h50);
      send(8'h2B, 1'b0, 1'b0, 1'b1);
      rd(1'b0, v); check("R12 recovers flags", v, 8'h55);
      rd(1'b1, v); check("R12 recovers data", v, 8'h2B);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule